// File: doc/BRIEF.md
# Reset-to-Run Start-up Sequencer

After a reset event this block keeps the processor core held and walks through a series of timed or handshaked phases. When the last phase is over it releases code execution. The reset cause and the clock-source class choose which phases run. A power-on reset first waits out a power-up period, whose length depends on whether the on-chip regulator is enabled. Every reset cause then reloads the configuration fuses and waits a further eight cycles. Power-on and brown-out resets may add an oscillator start-up wait, a PLL lock wait and a clock-monitor delay, depending on the clock source. All other reset causes go straight from the reload to run.

A request strobe starts a sequence and captures the reset cause, clock class, regulator enable and monitor enable that come with it. A new request in any phase, including run, restarts from the first phase that fits the new inputs. The configuration reload is a handshake with an external loader: the block pulses a start and waits for a done. Oscillator readiness and PLL lock arrive as strobes from outside. The power-up and monitor delays are counters set by parameters.

Top module: `startup_seq`

## Requirements
- R1: While `rst_n` is low, and after it rises until the first request, `phase_o` reads 0 (hold) and `run_o` and `cfg_load_start_o` are 0.
- R2: `phase_o` codes are 1 power-up, 2 fuse reload, 3 reload tail, 4 oscillator wait, 5 PLL wait, 6 monitor delay, 7 run. Phases that are used always appear in ascending code order, and unused phases are skipped.
- R3: Only `rst_kind_i` = 0 (power-on) has the power-up phase. It lasts exactly `PWRUP_REG_CYC` cycles when `reg_en_i` = 1 and `PWRUP_TMR_CYC` cycles when `reg_en_i` = 0.
- R4: Every sequence has the reload phase. `cfg_load_start_o` is high for exactly its first cycle. The phase lasts up to and including the cycle in which `cfg_load_done_i` is sampled high. It is followed by the tail phase, which lasts exactly 8 cycles.
- R5: The oscillator wait is present for `rst_kind_i` 0 or 1 (brown-out) when `clk_src_i` bit 1 is set (2 = crystal, 3 = crystal with PLL). It ends after the cycle in which `osc_ready_i` is high.
- R6: The PLL wait is present for `rst_kind_i` 0 or 1 when `clk_src_i` bit 0 is set (1 = RC with PLL, 3 = crystal with PLL). It ends after the cycle in which `pll_lock_i` is high.
- R7: The monitor delay is present for `rst_kind_i` 0 or 1 with `mon_en_i` = 1 and `clk_src_i` not 0 (0 = plain external clock or RC). It lasts exactly `MON_CYC` cycles.
- R8: For `rst_kind_i` 2 or 3 (pin, mismatch, software, watchdog), the sequence is reload, tail, run, whatever the clock class, regulator or monitor enable.
- R9: `run_o` is high for exactly the first cycle of the run phase. `phase_o` then stays at 7 until the next request.
- R10: `rst_req_i` high in any state makes the next cycle the first phase for the inputs sampled with that request: power-up for kind 0, reload otherwise. Inputs presented without a request are not used.
- R11: `cfg_load_done_i`, `osc_ready_i` and `pll_lock_i` have no effect outside their own phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset of the sequencer |
| rst_req_i | input | 1 | Reset-event strobe, starts or restarts a sequence |
| rst_kind_i | input | 2 | Reset cause: 0 power-on, 1 brown-out, 2/3 other |
| clk_src_i | input | 2 | Clock class: 0 plain, 1 RC+PLL, 2 crystal, 3 crystal+PLL |
| reg_en_i | input | 1 | On-chip regulator enabled |
| mon_en_i | input | 1 | Fail-safe clock monitor enabled |
| osc_ready_i | input | 1 | Oscillator start-up done strobe |
| pll_lock_i | input | 1 | PLL lock done strobe |
| cfg_load_done_i | input | 1 | Fuse reload done from the loader |
| cfg_load_start_o | output | 1 | Fuse reload start pulse to the loader |
| phase_o | output | 3 | Current phase code |
| run_o | output | 1 | One-cycle core-run release |

## Verification
The bench builds the block with `PWRUP_REG_CYC` = 5, `PWRUP_TMR_CYC` = 9 and `MON_CYC` = 4. With these values every timed phase is short, so both power-up lengths, the exact ends of the tail and monitor phases, and restarts in the middle of a power-up window can all be checked in a short run. The loader and strobe stubs use different latencies for each case and drive their strobes high outside their own phase. This exposes a strobe that is honoured in the wrong phase, and a handshake phase whose length is off by one.

// File: rtl/startup_seq_pkg.sv
package startup_seq_pkg;

    typedef enum logic [2:0] {
        PH_HOLD  = 3'd0,
        PH_PWRUP = 3'd1,
        PH_CFG   = 3'd2,
        PH_TAIL  = 3'd3,
        PH_OSC   = 3'd4,
        PH_PLL   = 3'd5,
        PH_FSCM  = 3'd6,
        PH_RUN   = 3'd7
    } phase_e;

    typedef enum logic [1:0] {
        RK_POWER  = 2'd0,
        RK_BROWN  = 2'd1,
        RK_OTHER  = 2'd2,
        RK_OTHER2 = 2'd3
    } rst_kind_e;

    typedef enum logic [1:0] {
        CS_PLAIN    = 2'd0,
        CS_RC_PLL   = 2'd1,
        CS_XTAL     = 2'd2,
        CS_XTAL_PLL = 2'd3
    } clk_src_e;

    typedef struct packed {
        rst_kind_e kind;
        clk_src_e  src;
        logic      reg_en;
        logic      mon_en;
    } seq_cfg_t;

    localparam int TAIL_CYC = 8;

    // Decide whether a phase belongs to the sequence for a captured setup.
    function automatic logic phase_used(phase_e ph, seq_cfg_t c);
        logic slow;
        logic use_it;
        slow = (c.kind == RK_POWER) || (c.kind == RK_BROWN);
        case (ph)
            PH_PWRUP: use_it = (c.kind == RK_POWER);
            PH_CFG,
            PH_TAIL:  use_it = 1'b1;
            PH_OSC:   use_it = slow && c.src[1];
            PH_PLL:   use_it = slow && c.src[0];
            PH_FSCM:  use_it = slow && c.mon_en && (c.src != CS_PLAIN);
            default:  use_it = 1'b0;
        endcase
        return use_it;
    endfunction

    // Lowest used phase above the given one, or run when none remains.
    function automatic phase_e phase_after(phase_e ph, seq_cfg_t c);
        phase_e nxt;
        nxt = PH_RUN;
        for (int i = 6; i >= 1; i--) begin
            if ((i > int'(ph)) && phase_used(phase_e'(3'(i)), c)) begin
                nxt = phase_e'(3'(i));
            end
        end
        return nxt;
    endfunction

endpackage

// File: rtl/seq_phase_plan.sv
module seq_phase_plan
    import startup_seq_pkg::*;
(
    input  seq_cfg_t req_cfg,
    input  seq_cfg_t run_cfg,
    input  phase_e   cur_ph,
    output phase_e   first_ph,
    output phase_e   after_ph
);

    always_comb begin
        first_ph = phase_after(PH_HOLD, req_cfg);
        after_ph = phase_after(cur_ph, run_cfg);
    end

endmodule

// File: rtl/seq_dwell_timer.sv
module seq_dwell_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/startup_seq.sv
module startup_seq
    import startup_seq_pkg::*;
#(
    parameter int PWRUP_REG_CYC = 1000,
    parameter int PWRUP_TMR_CYC = 4096,
    parameter int MON_CYC       = 256
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rst_req_i,
    input  logic [1:0] rst_kind_i,
    input  logic [1:0] clk_src_i,
    input  logic       reg_en_i,
    input  logic       mon_en_i,
    input  logic       osc_ready_i,
    input  logic       pll_lock_i,
    input  logic       cfg_load_done_i,
    output logic       cfg_load_start_o,
    output logic [2:0] phase_o,
    output logic       run_o
);

    localparam int MAX_A   = (PWRUP_REG_CYC > PWRUP_TMR_CYC) ? PWRUP_REG_CYC : PWRUP_TMR_CYC;
    localparam int MAX_B   = (MON_CYC > TAIL_CYC) ? MON_CYC : TAIL_CYC;
    localparam int MAX_CYC = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    localparam logic [CNT_W-1:0] REG_LD  = CNT_W'(PWRUP_REG_CYC - 1);
    localparam logic [CNT_W-1:0] TMR_LD  = CNT_W'(PWRUP_TMR_CYC - 1);
    localparam logic [CNT_W-1:0] TAIL_LD = CNT_W'(TAIL_CYC - 1);
    localparam logic [CNT_W-1:0] MON_LD  = CNT_W'(MON_CYC - 1);

    typedef struct packed {
        phase_e   phase;
        seq_cfg_t cfg;
        logic     run;
        logic     start;
    } seq_state_t;

    seq_state_t st_d, st_q;
    seq_cfg_t   req_cfg;
    phase_e     first_ph;
    phase_e     after_ph;
    logic       advance;
    logic       tmr_load;
    logic       tmr_zero;
    logic [CNT_W-1:0] tmr_val;

    assign req_cfg = '{kind:   rst_kind_e'(rst_kind_i),
                       src:    clk_src_e'(clk_src_i),
                       reg_en: reg_en_i,
                       mon_en: mon_en_i};

    seq_phase_plan plan_i (
        .req_cfg  (req_cfg),
        .run_cfg  (st_q.cfg),
        .cur_ph   (st_q.phase),
        .first_ph (first_ph),
        .after_ph (after_ph)
    );

    seq_dwell_timer #(
        .CNT_W (CNT_W)
    ) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    always_comb begin
        st_d = st_q;

        // completion condition of the phase in progress
        case (st_q.phase)
            PH_PWRUP, PH_TAIL, PH_FSCM: advance = tmr_zero;
            PH_CFG:                     advance = cfg_load_done_i;
            PH_OSC:                     advance = osc_ready_i;
            PH_PLL:                     advance = pll_lock_i;
            default:                    advance = 1'b0;
        endcase

        if (rst_req_i) begin
            st_d.cfg   = req_cfg;
            st_d.phase = first_ph;
        end else if (advance) begin
            st_d.phase = after_ph;
        end

        st_d.start = (st_d.phase == PH_CFG) && ((st_q.phase != PH_CFG) || rst_req_i);
        st_d.run   = (st_d.phase == PH_RUN) && (st_q.phase != PH_RUN);

        tmr_load = rst_req_i || (st_d.phase != st_q.phase);
        case (st_d.phase)
            PH_PWRUP: tmr_val = st_d.cfg.reg_en ? REG_LD : TMR_LD;
            PH_TAIL:  tmr_val = TAIL_LD;
            PH_FSCM:  tmr_val = MON_LD;
            default:  tmr_val = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_HOLD,
                      cfg:   '{kind: RK_POWER, src: CS_PLAIN, reg_en: 1'b0, mon_en: 1'b0},
                      run:   1'b0,
                      start: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign phase_o          = st_q.phase;
    assign run_o            = st_q.run;
    assign cfg_load_start_o = st_q.start;

endmodule

// File: rtl/startup_seq_chk.sv
module startup_seq_chk
    import startup_seq_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       rst_req_i,
    input logic [1:0] rst_kind_i,
    input logic       osc_ready_i,
    input logic       pll_lock_i,
    input logic       cfg_load_start_o,
    input logic [2:0] phase_o,
    input logic       run_o
);

    logic [3:0] tail_seen_q;
    logic [1:0] kind_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tail_seen_q <= '0;
            kind_q      <= '0;
        end else begin
            if (phase_o == PH_TAIL) begin
                if (tail_seen_q != 4'hF) tail_seen_q <= tail_seen_q + 1'b1;
            end else begin
                tail_seen_q <= '0;
            end
            if (rst_req_i) kind_q <= rst_kind_i;
        end
    end

    assert_req_power_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_req_i && rst_kind_i == 2'd0) |=> (phase_o == PH_PWRUP));

    assert_req_other_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_req_i && rst_kind_i != 2'd0) |=> (phase_o == PH_CFG));

    assert_start_in_cfg_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_load_start_o |-> (phase_o == PH_CFG));

    assert_tail_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == PH_TAIL) |-> (tail_seen_q < 4'd8));

    assert_tail_exit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == PH_TAIL && tail_seen_q == 4'd7 && !rst_req_i) |=> (phase_o != PH_TAIL));

    assert_osc_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == PH_OSC && !osc_ready_i && !rst_req_i) |=> (phase_o == PH_OSC));

    assert_pll_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == PH_PLL && !pll_lock_i && !rst_req_i) |=> (phase_o == PH_PLL));

    assert_other_short_R8: assert property (@(posedge clk) disable iff (!rst_n)
        kind_q[1] |-> (phase_o inside {PH_HOLD, PH_CFG, PH_TAIL, PH_RUN}));

    assert_brown_no_pwrup_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_q == 2'd1) |-> (phase_o != PH_PWRUP));

    assert_run_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        run_o |-> (phase_o == PH_RUN && $past(phase_o) != PH_RUN));

    assert_run_entry_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == PH_RUN && $past(phase_o) != PH_RUN) |-> run_o);

endmodule

bind startup_seq startup_seq_chk chk_i (
    .clk              (clk),
    .rst_n            (rst_n),
    .rst_req_i        (rst_req_i),
    .rst_kind_i       (rst_kind_i),
    .osc_ready_i      (osc_ready_i),
    .pll_lock_i       (pll_lock_i),
    .cfg_load_start_o (cfg_load_start_o),
    .phase_o          (phase_o),
    .run_o            (run_o)
);

// File: tb/startup_seq_tb_top.sv
module startup_seq_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int P_REG = 5;
    localparam int P_TMR = 9;
    localparam int P_MON = 4;

    localparam int C_HOLD = 0, C_PWRUP = 1, C_CFG = 2, C_TAIL = 3;
    localparam int C_OSC = 4, C_PLL = 5, C_MON = 6, C_RUN = 7;

    typedef struct {
        int    ph;
        int    len;
        string tag;
    } item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rst_req_i = 1'b0;
    logic [1:0] rst_kind_i = '0;
    logic [1:0] clk_src_i = '0;
    logic       reg_en_i = 1'b0;
    logic       mon_en_i = 1'b0;
    logic       osc_ready_i = 1'b0;
    logic       pll_lock_i = 1'b0;
    logic       cfg_load_done_i = 1'b0;
    logic       cfg_load_start_o;
    logic [2:0] phase_o;
    logic       run_o;

    int checks = 0;
    int errors = 0;
    int cfg_lat = 0, osc_lat = 0, pll_lat = 0;
    item_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    startup_seq #(
        .PWRUP_REG_CYC (P_REG),
        .PWRUP_TMR_CYC (P_TMR),
        .MON_CYC       (P_MON)
    ) dut_i (
        .clk              (clk),
        .rst_n            (rst_n),
        .rst_req_i        (rst_req_i),
        .rst_kind_i       (rst_kind_i),
        .clk_src_i        (clk_src_i),
        .reg_en_i         (reg_en_i),
        .mon_en_i         (mon_en_i),
        .osc_ready_i      (osc_ready_i),
        .pll_lock_i       (pll_lock_i),
        .cfg_load_done_i  (cfg_load_done_i),
        .cfg_load_start_o (cfg_load_start_o),
        .phase_o          (phase_o),
        .run_o            (run_o)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic push(input int ph, input int len, input string tag);
        item_t it;
        it.ph = ph; it.len = len; it.tag = tag;
        sb_q.push_back(it);
    endtask

    // Expected phase list from the requirements.
    task automatic push_plan(input int kind, input int src, input bit reg_en, input bit mon);
        bit slow;
        slow = (kind < 2);
        if (kind == 0) push(C_PWRUP, reg_en ? P_REG : P_TMR, "R3");
        push(C_CFG, cfg_lat + 1, slow ? "R4/R11" : "R8");
        push(C_TAIL, 8, slow ? "R4" : "R8");
        if (slow && src[1]) push(C_OSC, osc_lat + 1, "R5/R11");
        if (slow && src[0]) push(C_PLL, pll_lat + 1, "R6/R11");
        if (slow && mon && src != 0) push(C_MON, P_MON, "R7");
        push(C_RUN, 0, "R9");
    endtask

    // Called at a negedge: one-cycle request; returns at the next negedge.
    task automatic request(input int kind, input int src, input bit reg_en, input bit mon);
        rst_req_i  = 1'b1;
        rst_kind_i = 2'(kind);
        clk_src_i  = 2'(src);
        reg_en_i   = reg_en;
        mon_en_i   = mon;
        @(negedge clk);
        rst_req_i  = 1'b0;
        rst_kind_i = 2'(3 - kind);
        clk_src_i  = 2'(3 - src);
        reg_en_i   = ~reg_en;
        mon_en_i   = ~mon;
    endtask

    task automatic wait_phase(input int ph);
        while (int'(phase_o) != ph) @(negedge clk);
    endtask

    task automatic run_case(input int kind, input int src, input bit reg_en, input bit mon);
        push_plan(kind, src, reg_en, mon);
        @(negedge clk);
        request(kind, src, reg_en, mon);
        wait_phase(C_RUN);
        repeat (2) @(negedge clk);
    endtask

    // Stubs for loader, oscillator and PLL; strobes held high outside their phase (R11).
    initial begin
        int cc, oc, pc;
        cc = 0; oc = 0; pc = 0;
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                cfg_load_done_i = 1'b0; osc_ready_i = 1'b0; pll_lock_i = 1'b0;
            end else begin
                if (int'(phase_o) == C_CFG) begin cc++; cfg_load_done_i = (cc > cfg_lat); end
                else begin cc = 0; cfg_load_done_i = 1'b1; end
                if (int'(phase_o) == C_OSC) begin oc++; osc_ready_i = (oc > osc_lat); end
                else begin oc = 0; osc_ready_i = 1'b1; end
                if (int'(phase_o) == C_PLL) begin pc++; pll_lock_i = (pc > pll_lat); end
                else begin pc = 0; pll_lock_i = 1'b1; end
            end
        end
    end

    // Monitor: compresses phase runs and compares them against the queue.
    initial begin
        int prev, run_len, cur;
        bit entering;
        item_t it;
        prev = C_HOLD;
        run_len = 0;
        @(posedge rst_n);
        forever begin
            @(negedge clk);
            cur = int'(phase_o);
            if (cur != prev) begin
                if (prev != C_HOLD) begin
                    if (sb_q.size() == 0) begin
                        check(1'b0, "R2 unexpected phase", prev, -1);
                    end else begin
                        it = sb_q.pop_front();
                        check(it.ph == prev, {"R2 order ", it.tag}, prev, it.ph);
                        if (it.len != 0)
                            check(it.len == run_len, {"length ", it.tag}, run_len, it.len);
                    end
                end
                run_len = 1;
            end else begin
                run_len++;
            end
            entering = (cur == C_RUN) && (prev != C_RUN);
            if (entering || run_o) check(run_o == entering, "R9 run pulse", int'(run_o), int'(entering));
            entering = (cur == C_CFG) && (prev != C_CFG);
            if (entering || cfg_load_start_o)
                check(cfg_load_start_o == entering, "R4 start pulse", int'(cfg_load_start_o), int'(entering));
            prev = cur;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(phase_o == 3'd0, "R1 reset phase", int'(phase_o), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(phase_o == 3'd0, "R1 hold phase", int'(phase_o), 0);
        check(run_o == 1'b0, "R1 run low", int'(run_o), 0);
        check(cfg_load_start_o == 1'b0, "R1 start low", int'(cfg_load_start_o), 0);

        cfg_lat = 0; osc_lat = 2; pll_lat = 1;
        run_case(0, 0, 1'b1, 1'b1);          // R3 regulator on, plain clock
        cfg_lat = 3;
        run_case(0, 1, 1'b0, 1'b0);          // R3 timer path, R6 PLL
        run_case(0, 2, 1'b1, 1'b1);          // R5 crystal, R7 monitor
        cfg_lat = 1; osc_lat = 4; pll_lat = 3;
        run_case(1, 3, 1'b0, 1'b1);          // brown-out, crystal+PLL, monitor
        run_case(1, 0, 1'b1, 1'b1);          // brown-out, plain clock
        run_case(2, 3, 1'b0, 1'b1);          // R8 other cause
        run_case(3, 1, 1'b1, 1'b0);          // R8 other cause, second code

        // R10: restart in power-up by a brown-out request
        push(C_PWRUP, 3, "R10");
        push_plan(1, 1, 1'b0, 1'b0);
        @(negedge clk);
        request(0, 0, 1'b1, 1'b0);
        repeat (2) @(negedge clk);
        request(1, 1, 1'b0, 1'b0);
        wait_phase(C_RUN);
        repeat (2) @(negedge clk);

        // R10: restart during oscillator wait by an other-cause request
        osc_lat = 20; cfg_lat = 0;
        push(C_PWRUP, P_TMR, "R3");
        push(C_CFG, 1, "R4");
        push(C_TAIL, 8, "R4");
        push(C_OSC, 3, "R10");
        push_plan(2, 2, 1'b0, 1'b0);
        @(negedge clk);
        request(0, 2, 1'b0, 1'b0);
        wait_phase(C_OSC);
        repeat (2) @(negedge clk);
        request(2, 2, 1'b0, 1'b0);
        wait_phase(C_RUN);
        repeat (4) @(negedge clk);

        check(phase_o == 3'd7, "R9 run holds", int'(phase_o), 7);
        check(sb_q.size() == 1, "R2 queue drained", sb_q.size(), 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule